// File: doc/BRIEF.md
# Composite Sync Separator with Horizontal Pulse Fill-In

This block sits behind the sync input pins of a display controller. In separate mode it passes the horizontal and vertical sync inputs combinationally to its outputs. In composite mode it takes a single composite sync stream on the horizontal input and produces a horizontal and a vertical output from it.

In composite mode the block recognises the vertical interval as an unusually long active pulse and raises the vertical output while that pulse lasts. It then holds the vertical output for a fixed stretch afterwards. It also keeps measuring the spacing of the real horizontal pulses. During the vertical interval, real line pulses are often absent. If fill-in is enabled, the block generates fixed-width horizontal pulses at the last measured spacing until real pulses return. Each output has its own polarity control. Every input is active-low, and all composite processing runs on a single 8 MHz clock after a two-flop synchroniser.

Top module: `csync_separator`

## Requirements
- R1: When `sep_mode` is 1, `hs_out` equals `hpol_pos ? ~hs_in : hs_in` and `vs_out` equals `vpol_pos ? ~vs_in : vs_in`, in the same cycle, with no clocking.
- R2: When `sep_mode` is 0, a low run of `hs_in` lasting at least 64 clocks is treated as vertical. The vertical output becomes active 66 clocks after the falling input edge. It stays active until 74 clocks after the input returns high, which is a 72-clock stretch plus the pipeline. A low run of 63 clocks never activates it.
- R3: In composite mode, `hs_out` shows the active level of `hs_in` delayed by 2 clocks. The only exception is while a low run is classified as vertical: from that moment until the run ends, the real level is masked.
- R4: The fill-in spacing P is the distance, in clocks, between the last two real falling edges before the vertical run. The spacing is measured with a 12-bit counter that saturates at 4095.
- R5: If `insert_n` is 0 and P is between 67 and 4094, fill-in pulses are 16 clocks wide. The k-th pulse (k = 1, 2, ...) begins 3 + k·P clocks after the falling edge of the vertical run. A pulse begins only if the vertical output was active in the clock before it.
- R6: If `insert_n` is 1, no fill-in pulse is generated, and `hs_out` stays inactive once the vertical classification has been made.
- R7: No fill-in occurs if fewer than two real falling edges preceded the vertical run since reset, or if the measured spacing reached 4095.
- R8: A real falling edge that arrives while fill-in is running stops all later fill-in pulses. A pulse already in progress completes its 16 clocks.
- R9: In composite mode, a polarity bit of 1 makes the corresponding output active-high, and a polarity bit of 0 makes it active-low.
- R10: In composite mode, `vs_in` has no effect on either output.
- R11: During and right after reset in composite mode, both outputs sit at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz processing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sep_mode | input | 1 | 1: separate passthrough, 0: composite separation |
| insert_n | input | 1 | 0 enables horizontal fill-in during vertical |
| hpol_pos | input | 1 | Horizontal output polarity, 1 = active-high |
| vpol_pos | input | 1 | Vertical output polarity, 1 = active-high |
| hs_in | input | 1 | Horizontal or composite sync in, active-low |
| vs_in | input | 1 | Vertical sync in (separate mode), active-low |
| hs_out | output | 1 | Horizontal sync out |
| vs_out | output | 1 | Vertical sync out |

## Verification
A wrong width count or a stuck stretch counter moves the edges of the vertical output. The error shows at the ports within one frame, on the exact clock at which the bench expects `vs_out` to change. A corrupted period register or phase counter shifts the first fill-in pulse away from 3 + P clocks after the vertical edge. A lost enable or validity flag adds or removes whole 16-clock pulses. Each scenario compares both outputs on every clock against a timeline computed from the stated latencies, so a divergence is caught at its first cycle.

// File: rtl/csep_pkg.sv
// Shared defaults and helpers for the composite sync separator.
// Assumes an 8 MHz clock; all time constants are expressed in clocks.
package csep_pkg;
    localparam int CSEP_CNT_W   = 12;  // line period counter width
    localparam int CSEP_VTHR    = 64;  // 8 us: minimum low run seen as vertical
    localparam int CSEP_STRETCH = 72;  // 9 us: vertical hold after run ends
    localparam int CSEP_INS_W   = 16;  // 2 us: fill-in pulse width

    // Map an active-high internal pulse to the requested output sense.
    function automatic logic apply_pol(input logic active, input logic pos);
        return pos ? active : ~active;
    endfunction
endpackage

// File: rtl/csep_sync.sv
// Two-flop synchroniser for asynchronous sync inputs.
// Assumes inputs idle at IDLE_LVL; reset loads that level so no edge is
// seen on release.
module csep_sync #(
    parameter int   W        = 1,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= {W{IDLE_LVL}};
            q    <= {W{IDLE_LVL}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/csep_period_meter.sv
// Measures the spacing of leading edges of the synchronised active pulse.
// 'elapsed' counts clocks since the latest leading edge. 'line_per' holds
// the spacing between the two edges before that one. Counters saturate.
// 'per_ok' needs three edges since reset and a non-saturated spacing.
module csep_period_meter #(
    parameter int CNT_W = csep_pkg::CSEP_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    output logic             lead,
    output logic [CNT_W-1:0] elapsed,
    output logic [CNT_W-1:0] line_per,
    output logic             per_ok
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             act_d;
    logic [CNT_W-1:0] per_last;
    logic [1:0]       n_edge;

    assign lead   = act & ~act_d;
    assign per_ok = (n_edge == 2'd3) && (line_per != CNT_MAX);

    // Delay of the active level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_d <= 1'b0;
        else        act_d <= act;
    end

    // Saturating clock count since the latest leading edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                  elapsed <= '0;
        else if (lead)               elapsed <= CNT_W'(1);
        else if (elapsed != CNT_MAX) elapsed <= elapsed + CNT_W'(1);
    end

    // Two-deep history of measured spacings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_last <= '0;
            line_per <= '0;
        end else if (lead) begin
            per_last <= elapsed;
            line_per <= per_last;
        end
    end

    // Saturating count of edges since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                          n_edge <= 2'd0;
        else if (lead && n_edge != 2'd3)     n_edge <= n_edge + 2'd1;
    end
endmodule

// File: rtl/csep_vdetect.sv
// Classifies a long active run as vertical and stretches the result.
// 'v_raw' rises once the run has lasted VTHR clocks and falls when the run
// ends. 'v_win' additionally covers STRETCH clocks after that.
module csep_vdetect #(
    parameter int VTHR    = csep_pkg::CSEP_VTHR,
    parameter int STRETCH = csep_pkg::CSEP_STRETCH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    output logic v_raw,
    output logic v_win
);
    localparam int WC_W = $clog2(VTHR + 1);
    localparam int ST_W = $clog2(STRETCH + 1);
    localparam logic [WC_W-1:0] WC_MAX = WC_W'(VTHR);
    localparam logic [WC_W-1:0] WC_HIT = WC_W'(VTHR - 1);

    logic [WC_W-1:0] wcnt;
    logic [ST_W-1:0] hold;

    assign v_win = v_raw | (hold != '0);

    // Length of the current active run, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !act)      wcnt <= '0;
        else if (wcnt != WC_MAX) wcnt <= wcnt + WC_W'(1);
    end

    // Vertical classification of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n || !act)      v_raw <= 1'b0;
        else if (wcnt == WC_HIT) v_raw <= 1'b1;
    end

    // Post-run hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold <= '0;
        else if (v_raw && !act)  hold <= ST_W'(STRETCH);
        else if (hold != '0)     hold <= hold - ST_W'(1);
    end

    a_r2_vert_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        v_raw |-> $past(act));
    a_r2_stretch_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(v_raw) |-> v_win);
endmodule

// File: rtl/csep_inserter.sv
// Generates fixed-width horizontal fill-in pulses inside the vertical window.
// On vertical classification it captures the last line spacing and aligns
// its phase to the vertical leading edge via 'elapsed'. A real leading edge
// or the end of the window stops it. Assumes spacing > VTHR + 2.
module csep_inserter #(
    parameter int CNT_W = csep_pkg::CSEP_CNT_W,
    parameter int INS_W = csep_pkg::CSEP_INS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insert_n,
    input  logic             v_raw,
    input  logic             v_win,
    input  logic             lead,
    input  logic [CNT_W-1:0] elapsed,
    input  logic [CNT_W-1:0] line_per,
    input  logic             per_ok,
    output logic             ins_act
);
    localparam int PW_W = $clog2(INS_W + 1);
    localparam logic [PW_W-1:0]  PW_FULL = PW_W'(INS_W);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             v_raw_q;
    logic             ins_on;
    logic [CNT_W-1:0] ph;
    logic [CNT_W-1:0] per_l;
    logic [PW_W-1:0]  pw;
    logic             v_rise;
    logic             fire;

    assign v_rise  = v_raw & ~v_raw_q;
    assign fire    = ins_on && v_win && !lead && (ph >= per_l);
    assign ins_act = (pw != '0);

    // Edge memory for vertical classification.
    always_ff @(posedge clk) begin
        if (!rst_n) v_raw_q <= 1'b0;
        else        v_raw_q <= v_raw;
    end

    // Fill-in enable, spacing capture and phase tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_on <= 1'b0;
            ph     <= '0;
            per_l  <= '0;
        end else if (v_rise) begin
            ins_on <= ~insert_n & per_ok;
            per_l  <= line_per;
            ph     <= (elapsed == CNT_MAX) ? CNT_MAX : elapsed + CNT_W'(1);
        end else if (lead || !v_win) begin
            ins_on <= 1'b0;
        end else if (fire) begin
            ph <= CNT_W'(1);
        end else if (ins_on && ph != CNT_MAX) begin
            ph <= ph + CNT_W'(1);
        end
    end

    // Pulse width down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n)         pw <= '0;
        else if (fire)      pw <= PW_FULL;
        else if (pw != '0)  pw <= pw - PW_W'(1);
    end

    a_r5_fire_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (pw == PW_FULL) |-> $past(v_win));
    a_r7_on_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_on) |-> ($past(per_ok) && !$past(insert_n)));
    a_r8_real_edge_stops: assert property (@(posedge clk) disable iff (!rst_n)
        lead |=> !ins_on);
    a_r6_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (insert_n && v_rise) |=> !ins_on);
endmodule

// File: rtl/csync_separator.sv
// Top level: separate-sync passthrough or composite separation with
// horizontal fill-in during the vertical interval. Inputs are active-low;
// outputs follow the polarity bits. Separate mode is purely combinational.
module csync_separator #(
    parameter int CNT_W   = csep_pkg::CSEP_CNT_W,
    parameter int VTHR    = csep_pkg::CSEP_VTHR,
    parameter int STRETCH = csep_pkg::CSEP_STRETCH,
    parameter int INS_W   = csep_pkg::CSEP_INS_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sep_mode,
    input  logic insert_n,
    input  logic hpol_pos,
    input  logic vpol_pos,
    input  logic hs_in,
    input  logic vs_in,
    output logic hs_out,
    output logic vs_out
);
    import csep_pkg::*;

    logic             cs_q;
    logic             act;
    logic             lead;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] line_per;
    logic             per_ok;
    logic             v_raw;
    logic             v_win;
    logic             ins_act;
    logic             h_comp;

    csep_sync #(.W(1), .IDLE_LVL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(hs_in), .q(cs_q)
    );

    assign act = ~cs_q;

    csep_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .act(act), .lead(lead),
        .elapsed(elapsed), .line_per(line_per), .per_ok(per_ok)
    );

    csep_vdetect #(.VTHR(VTHR), .STRETCH(STRETCH)) u_vdet (
        .clk(clk), .rst_n(rst_n), .act(act), .v_raw(v_raw), .v_win(v_win)
    );

    csep_inserter #(.CNT_W(CNT_W), .INS_W(INS_W)) u_ins (
        .clk(clk), .rst_n(rst_n), .insert_n(insert_n), .v_raw(v_raw),
        .v_win(v_win), .lead(lead), .elapsed(elapsed), .line_per(line_per),
        .per_ok(per_ok), .ins_act(ins_act)
    );

    // Composite horizontal: real level masked while classified vertical.
    assign h_comp = (act & ~v_raw) | ins_act;

    // Output selection and polarity.
    always_comb begin
        if (sep_mode) begin
            hs_out = apply_pol(~hs_in, hpol_pos);
            vs_out = apply_pol(~vs_in, vpol_pos);
        end else begin
            hs_out = apply_pol(h_comp, hpol_pos);
            vs_out = apply_pol(v_win, vpol_pos);
        end
    end

    a_r3_masked_in_vertical: assert property (@(posedge clk) disable iff (!rst_n)
        (!sep_mode && v_raw && !ins_act) |-> (hs_out == ~hpol_pos));
endmodule

// File: tb/csync_separator_test.sv
`timescale 1ns/1ps
module csync_separator_test;
    localparam int CLK_NS = 125;
    localparam int MAXN   = 8192;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sep_mode = 1'b0, insert_n = 1'b1, hpol_pos = 1'b1, vpol_pos = 1'b1;
    logic hs_in = 1'b1, vs_in = 1'b1;
    logic hs_out, vs_out;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic pat [MAXN];
    logic ea  [MAXN];
    logic vr  [MAXN];
    logic vw  [MAXN];
    logic ins [MAXN];
    logic eh  [MAXN];
    int   falls [64];
    int   plen, nf;

    csync_separator uut (
        .clk(clk), .rst_n(rst_n), .sep_mode(sep_mode), .insert_n(insert_n),
        .hpol_pos(hpol_pos), .vpol_pos(vpol_pos), .hs_in(hs_in), .vs_in(vs_in),
        .hs_out(hs_out), .vs_out(vs_out)
    );

    always #(CLK_NS / 2.0) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pat_add(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            pat[plen] = v;
            plen++;
        end
    endtask

    task automatic pat_line(input int per, input int w);
        pat_add(1'b0, w);
        pat_add(1'b1, per - w);
    endtask

    // Expected timeline from the stated latencies.
    task automatic build_model(input logic ins_dis);
        for (int i = 0; i < plen; i++) begin
            ea[i]  = (i >= 2) ? ~pat[i-2] : 1'b0;
            vr[i]  = 1'b0;
            vw[i]  = 1'b0;
            ins[i] = 1'b0;
        end
        nf = 0;
        for (int i = 0; i < plen; i++)
            if (pat[i] == 1'b0 && (i == 0 || pat[i-1] == 1'b1)) begin
                falls[nf] = i;
                nf++;
            end
        for (int k = 0; k < nf; k++) begin
            int t, len, vend, per;
            t = falls[k];
            len = 0;
            while (t + len < plen && pat[t+len] == 1'b0) len++;
            if (len >= 64) begin
                vend = t + len + 74;
                for (int i = t + 66; i <= vend && i < plen; i++) vw[i] = 1'b1;
                for (int i = t + 66; i <= t + len + 2 && i < plen; i++) vr[i] = 1'b1;
                if (!ins_dis && k >= 2) begin
                    per = falls[k-1] - falls[k-2];
                    if (per < 4095) begin
                        for (int m = 1; m < 64; m++) begin
                            int s;
                            bit stop;
                            s = t + 2 + m * per;
                            if (s > vend) break;
                            stop = 1'b0;
                            for (int q = k + 1; q < nf; q++)
                                if (falls[q] + 2 <= s) stop = 1'b1;
                            if (stop) break;
                            for (int j = 0; j < 16; j++)
                                if (s + 1 + j < plen) ins[s+1+j] = 1'b1;
                        end
                    end
                end
            end
        end
        for (int i = 0; i < plen; i++) eh[i] = (ea[i] & ~vr[i]) | ins[i];
    endtask

    task automatic do_reset(input logic insn, input logic hp, input logic vp);
        @(negedge clk);
        rst_n = 1'b0; sep_mode = 1'b0; insert_n = insn;
        hpol_pos = hp; vpol_pos = vp; hs_in = 1'b1; vs_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Replay the pattern and compare both outputs on every clock.
    task automatic play(input string req, input bit tog_vs);
        int mh = 0, mv = 0, fh = -1, fv = -1, ah = 0, xh = 0, av = 0, xv = 0;
        logic eh_o, ev_o;
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            eh_o = hpol_pos ? eh[i] : ~eh[i];
            ev_o = vpol_pos ? vw[i] : ~vw[i];
            if (hs_out !== eh_o) begin
                if (fh < 0) begin fh = i; ah = int'(hs_out); xh = int'(eh_o); end
                mh++;
            end
            if (vs_out !== ev_o) begin
                if (fv < 0) begin fv = i; av = int'(vs_out); xv = int'(ev_o); end
                mv++;
            end
            hs_in = pat[i];
            if (tog_vs) vs_in = ~vs_in;
        end
        chk(mh == 0, req, $sformatf("hs_out first bad clock %0d", fh), ah, xh);
        chk(mv == 0, req, $sformatf("vs_out first bad clock %0d", fv), av, xv);
    endtask

    task automatic run(input string req, input logic insn, input logic hp,
                       input logic vp, input bit tog_vs);
        build_model(insn);
        do_reset(insn, hp, vp);
        play(req, tog_vs);
    endtask

    // R11: reset state in composite mode, both polarities.
    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; sep_mode = 1'b0; hpol_pos = 1'b1; vpol_pos = 1'b1;
        hs_in = 1'b0; vs_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(hs_out == 1'b0, "R11", "hs_out in reset", int'(hs_out), 0);
        chk(vs_out == 1'b0, "R11", "vs_out in reset", int'(vs_out), 0);
        hpol_pos = 1'b0; vpol_pos = 1'b0; hs_in = 1'b1; vs_in = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(hs_out == 1'b1, "R11", "hs_out after reset", int'(hs_out), 1);
        chk(vs_out == 1'b1, "R11", "vs_out after reset", int'(vs_out), 1);
    endtask

    // R1: separate-mode combinational passthrough.
    task automatic t_separate;
        sep_mode = 1'b1;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            hs_in = c[0]; vs_in = c[1]; hpol_pos = c[2]; vpol_pos = c[3];
            #1;
            chk(hs_out == (hpol_pos ? ~hs_in : hs_in) &&
                vs_out == (vpol_pos ? ~vs_in : vs_in), "R1",
                $sformatf("passthrough combo %0d hs/vs", c),
                int'({hs_out, vs_out}),
                int'({hpol_pos ? ~hs_in : hs_in, vpol_pos ? ~vs_in : vs_in}));
        end
        sep_mode = 1'b0;
    endtask

    task automatic lines(input int n, input int per);
        for (int i = 0; i < n; i++) pat_line(per, 8);
    endtask

    task automatic t_lines;  // R3: real pulses, no vertical
        plen = 0; pat_add(1'b1, 20); lines(6, 100); pat_add(1'b1, 100);
        run("R3", 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_thresh;  // R2: 63 vs 64 clock low runs
        plen = 0; pat_add(1'b1, 20); pat_add(1'b0, 63); pat_add(1'b1, 200);
        pat_add(1'b0, 64); pat_add(1'b1, 200);
        run("R2", 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_insert;  // R5: four fill-in pulses at spacing 100
        plen = 0; pat_add(1'b1, 20); lines(5, 100); pat_add(1'b0, 400);
        pat_add(1'b1, 100); lines(3, 100); pat_add(1'b1, 150);
        run("R5", 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_noins;  // R6: fill-in disabled
        plen = 0; pat_add(1'b1, 20); lines(5, 100); pat_add(1'b0, 400);
        pat_add(1'b1, 100); lines(3, 100); pat_add(1'b1, 150);
        run("R6", 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_resync;  // R8: real edge inside stretch stops fill-in
        plen = 0; pat_add(1'b1, 20); lines(5, 100); pat_add(1'b0, 350);
        pat_add(1'b1, 20); lines(3, 100); pat_add(1'b1, 150);
        run("R8", 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_few;  // R7: one real line only
        plen = 0; pat_add(1'b1, 20); lines(1, 100); pat_add(1'b0, 400);
        pat_add(1'b1, 200);
        run("R7", 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_sat;  // R4 and R7: saturated spacing suppresses fill-in
        plen = 0; pat_add(1'b1, 20); pat_line(5000, 8); pat_line(100, 8);
        pat_add(1'b0, 400); pat_add(1'b1, 200);
        run("R4 saturation R7", 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_period;  // R4: spacing taken from last two real edges
        plen = 0; pat_add(1'b1, 20); lines(2, 150); lines(2, 180);
        pat_add(1'b0, 500); pat_add(1'b1, 200);
        run("R4", 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_pol;  // R9 and R10: inverted outputs, vs_in toggling
        plen = 0; pat_add(1'b1, 20); lines(5, 100); pat_add(1'b0, 400);
        pat_add(1'b1, 100); lines(2, 100); pat_add(1'b1, 150);
        run("R9 polarity R10", 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_separate();
        t_lines();
        t_thresh();
        t_insert();
        t_noins();
        t_resync();
        t_few();
        t_sat();
        t_period();
        t_pol();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule